// File: doc/BRIEF.md
# Segmented Receive Bus Protocol Checker

This block watches a 512-bit receive bus split into four 128-bit segments and checks, without touching the traffic, that packet framing on the bus is legal. Each segment carries its own enable, start-of-packet, end-of-packet, error flag and 4-bit empty count. The checker walks the segments from 0 to 3 within each clock cycle. It carries the packet-open state from segment 3 of one cycle into segment 0 of the next. It reports rule breaks as sticky flags and as a one-cycle pulse with a code.

The block also keeps two saturating counters, one for packets that end without error and one for packets that end with error. It is meant to be placed beside a receive path in simulation or silicon as a protocol watchdog. It looks only at the control fields of each segment. It does not look at the data, check the CRC or parse frames.

Top module: `seg_rx_monitor`

## Requirements
- R1: After reset all sticky flags, the pulse, the code and both counters are 0, and no packet is open.
- R2: A segment whose enable is 0 has no effect on flags, pulse, code, counters or packet state, whatever its other fields hold.
- R3: An enabled segment with start 1 while a packet is open sets sticky bit 0 and reports code 1. The packet is then treated as restarted.
- R4: An enabled segment with start 0 while no packet is open sets sticky bit 1 and reports code 2. The packet is then treated as open from that transfer.
- R5: An enabled segment with end 1 and error 1 whose empty-count bits [2:0] are not 000 sets sticky bit 2 and reports code 3. Empty bit 3 takes no part in this rule. Error and empty count are ignored when end is 0.
- R6: Within a cycle, segments are evaluated in ascending order 0 to 3. The open state left by segment 3 applies to segment 0 of the next enabled cycle.
- R7: A packet made of one segment, with start and end both 1, is legal and counts as a complete packet.
- R8: A violation drives the pulse high for exactly the cycle after the offending input. The code reports the lowest-numbered offending segment; within that segment, codes 1 and 2 take precedence over code 3. With no violation, the pulse and the code are 0.
- R9: Sticky flags stay set until clear_i is sampled high. A violation in the same cycle as clear_i is still recorded.
- R10: Each enabled end with error 0 adds 1 to good_cnt_o, and each enabled end with error 1 adds 1 to bad_cnt_o. This holds even when the same transfer breaks a rule. Up to four packets can be added in one cycle, and both counters saturate at all ones.
- R11: The empty count of segment k sits in seg_mty_i[4k+3:4k], and the other per-segment fields sit at bit k of their vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Clears the sticky violation flags |
| seg_en_i | input | 4 | Per-segment enable |
| seg_sop_i | input | 4 | Per-segment start of packet |
| seg_eop_i | input | 4 | Per-segment end of packet |
| seg_err_i | input | 4 | Per-segment error flag |
| seg_mty_i | input | 16 | Per-segment empty count, 4 bits per segment |
| viol_sticky_o | output | 3 | Sticky flags: bit0 start while open, bit1 missing start, bit2 bad empty on error |
| viol_pulse_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 2 | Code of the reported violation (0 = none) |
| good_cnt_o | output | 16 | Saturating count of packets ended without error |
| bad_cnt_o | output | 16 | Saturating count of packets ended with error |

## Verification
The assertions check several rules on every cycle. A start in segment 0 while a packet is open, or a missing start in segment 0 while none is open, must raise the pulse on the next cycle. An errored end in segment 0 with nonzero low empty bits must set its sticky flag. A pulse must always be matched by a set sticky flag. Sticky flags may fall only after a clear. The counters may never decrease.

Only the bench scenarios can show the rest. These cover the ascending-order priority when several segments break rules in one cycle, and open state carried across cycle boundaries. They also cover disabled segments with stray fields, a clear that coincides with a new violation, and the exact counter values through saturation.

// File: rtl/seg_mon_pkg.sv
package seg_mon_pkg;
  localparam int NKIND = 3;
  localparam logic [1:0] VC_NONE     = 2'd0;
  localparam logic [1:0] VC_SOP_OPEN = 2'd1;
  localparam logic [1:0] VC_NO_SOP   = 2'd2;
  localparam logic [1:0] VC_ERR_MTY  = 2'd3;
endpackage

// File: rtl/seg_lane_chk.sv
module seg_lane_chk #(
  parameter int MTY_W = 4
) (
  input  logic             open_i,
  input  logic             en_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic             err_i,
  input  logic [MTY_W-1:0] mty_i,
  output logic             open_o,
  output logic [2:0]       hit_o,
  output logic             good_o,
  output logic             bad_o
);
  always_comb begin
    hit_o  = '0;
    open_o = open_i;
    good_o = 1'b0;
    bad_o  = 1'b0;
    if (en_i) begin
      hit_o[0] = sop_i && open_i;
      hit_o[1] = !sop_i && !open_i;
      hit_o[2] = eop_i && err_i && (mty_i[2:0] != 3'b000);
      open_o   = !eop_i;
      good_o   = eop_i && !err_i;
      bad_o    = eop_i && err_i;
    end
  end
endmodule

// File: rtl/seg_sat_cnt.sv
module seg_sat_cnt #(
  parameter int W     = 16,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W:0] sum_w;
  assign sum_w = {1'b0, cnt_o} + (W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (sum_w[W]) cnt_o <= '1;
    else              cnt_o <= sum_w[W-1:0];
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o >= $past(cnt_o)); // R10
endmodule

// File: rtl/seg_rx_monitor.sv
module seg_rx_monitor
  import seg_mon_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int MTY_W = 4,
  parameter int CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic [NSEG-1:0]       seg_en_i,
  input  logic [NSEG-1:0]       seg_sop_i,
  input  logic [NSEG-1:0]       seg_eop_i,
  input  logic [NSEG-1:0]       seg_err_i,
  input  logic [NSEG*MTY_W-1:0] seg_mty_i,
  output logic [NKIND-1:0]      viol_sticky_o,
  output logic                  viol_pulse_o,
  output logic [1:0]            viol_code_o,
  output logic [CNT_W-1:0]      good_cnt_o,
  output logic [CNT_W-1:0]      bad_cnt_o
);
  localparam int INC_W = $clog2(NSEG + 1);

  logic             open_q;
  logic [NSEG:0]    open_c;
  logic [2:0]       hit   [NSEG];
  logic [NSEG-1:0]  good_v, bad_v;
  logic [NKIND-1:0] hit_any;
  logic [1:0]       code_d;
  logic [INC_W-1:0] good_inc, bad_inc;

  assign open_c[0] = open_q;

  // segment chain, ascending order
  for (genvar k = 0; k < NSEG; k++) begin : g_lane
    seg_lane_chk #(.MTY_W(MTY_W)) u_lane (
      .open_i (open_c[k]),
      .en_i   (seg_en_i[k]),
      .sop_i  (seg_sop_i[k]),
      .eop_i  (seg_eop_i[k]),
      .err_i  (seg_err_i[k]),
      .mty_i  (seg_mty_i[k*MTY_W +: MTY_W]),
      .open_o (open_c[k+1]),
      .hit_o  (hit[k]),
      .good_o (good_v[k]),
      .bad_o  (bad_v[k])
    );
  end

  always_comb begin
    hit_any  = '0;
    code_d   = VC_NONE;
    good_inc = '0;
    bad_inc  = '0;
    for (int k = NSEG-1; k >= 0; k--) begin
      hit_any  = hit_any | hit[k];
      good_inc = good_inc + INC_W'(good_v[k]);
      bad_inc  = bad_inc + INC_W'(bad_v[k]);
      if (hit[k] != 3'b000) begin
        if (hit[k][0])      code_d = VC_SOP_OPEN;
        else if (hit[k][1]) code_d = VC_NO_SOP;
        else                code_d = VC_ERR_MTY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q        <= 1'b0;
      viol_sticky_o <= '0;
      viol_pulse_o  <= 1'b0;
      viol_code_o   <= VC_NONE;
    end else begin
      open_q        <= open_c[NSEG];
      viol_sticky_o <= (clear_i ? '0 : viol_sticky_o) | hit_any;
      viol_pulse_o  <= |hit_any;
      viol_code_o   <= code_d;
    end
  end

  seg_sat_cnt #(.W(CNT_W), .INC_W(INC_W)) u_good (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(good_inc), .cnt_o(good_cnt_o));
  seg_sat_cnt #(.W(CNT_W), .INC_W(INC_W)) u_bad (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(bad_inc), .cnt_o(bad_cnt_o));

  AST_SOP_OPEN_SEG0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && seg_en_i[0] && seg_sop_i[0]) |=> viol_pulse_o); // R3
  AST_NO_SOP_SEG0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && seg_en_i[0] && !seg_sop_i[0]) |=> viol_pulse_o); // R4
  AST_ERR_MTY_SEG0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_en_i[0] && seg_eop_i[0] && seg_err_i[0] && (seg_mty_i[2:0] != 3'b000))
    |=> viol_sticky_o[2]); // R5
  AST_PULSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_pulse_o |-> (viol_code_o != VC_NONE) && viol_sticky_o[viol_code_o - 2'd1]); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> ((viol_sticky_o & $past(viol_sticky_o)) == $past(viol_sticky_o))); // R9
endmodule

// File: tb/seg_rx_monitor_test.sv
module seg_rx_monitor_test;
  localparam int CW = 6;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic [3:0] en = '0, sop = '0, eop = '0, err = '0;
  logic [15:0] mty = '0;
  logic [2:0] sticky;
  logic pulse;
  logic [1:0] code;
  logic [CW-1:0] good, bad;

  int n_chk = 0, n_bad = 0;
  int m_open = 0, m_good = 0, m_bad = 0, m_pulse = 0, m_code = 0;
  logic [2:0] m_sticky = '0;

  always #10 clk = ~clk;

  seg_rx_monitor #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr),
    .seg_en_i(en), .seg_sop_i(sop), .seg_eop_i(eop), .seg_err_i(err), .seg_mty_i(mty),
    .viol_sticky_o(sticky), .viol_pulse_o(pulse), .viol_code_o(code),
    .good_cnt_o(good), .bad_cnt_o(bad));

  task automatic check(string tag);
    n_chk++;
    if (sticky !== m_sticky || pulse !== m_pulse[0] || code !== m_code[1:0] ||
        good !== CW'(m_good) || bad !== CW'(m_bad)) begin
      n_bad++;
      $display("FAIL %s: sticky=%b pulse=%b code=%0d good=%0d bad=%0d, expected %b %0d %0d %0d %0d",
               tag, sticky, pulse, code, good, bad, m_sticky, m_pulse, m_code, m_good, m_bad);
    end
  endtask

  task automatic seg(int k, bit e, bit s, bit o, bit r, logic [3:0] m);
    en[k] = e; sop[k] = s; eop[k] = o; err[k] = r; mty[4*k +: 4] = m;
  endtask

  task automatic model();
    logic [2:0] hits = '0;
    int c = 0;
    for (int k = 0; k < 4; k++) begin
      if (en[k]) begin
        logic [2:0] h = '0;
        if (sop[k] && m_open == 1) h[0] = 1'b1;
        if (!sop[k] && m_open == 0) h[1] = 1'b1;
        if (eop[k] && err[k] && mty[4*k +: 3] != 3'b000) h[2] = 1'b1;
        if (c == 0 && h != 0) c = h[0] ? 1 : (h[1] ? 2 : 3);
        hits |= h;
        if (eop[k]) begin
          if (err[k]) m_bad++; else m_good++;
        end
        m_open = eop[k] ? 0 : 1;
      end
    end
    if (m_good > 2**CW - 1) m_good = 2**CW - 1;
    if (m_bad > 2**CW - 1) m_bad = 2**CW - 1;
    m_sticky = (clr ? 3'b000 : m_sticky) | hits;
    m_pulse = (hits != 0) ? 1 : 0;
    m_code = c;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    check(tag);
    en = '0; sop = '0; eop = '0; err = '0; mty = '0; clr = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog (R1..R11 incomplete): actual hung, expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    step("R1 idle");
    // multi-cycle clean packet, R6 state carried across cycles
    seg(0,1,1,0,0,0); seg(1,1,0,0,0,0); seg(2,1,0,0,0,0); seg(3,1,0,0,0,0);
    step("R6 open");
    seg(0,1,0,0,0,0); seg(1,1,0,1,0,4'd5);
    step("R6 close");
    // four single-segment packets, R7
    for (int k = 0; k < 4; k++) seg(k,1,1,1,0,4'd3);
    step("R7 singles");
    // disabled segments with stray fields, R2
    seg(0,0,0,1,1,4'd7); seg(1,0,1,1,1,4'd1); seg(2,0,0,0,0,0); seg(3,0,1,0,1,4'd2);
    step("R2 disabled");
    // start while open, R3
    seg(2,1,1,0,0,0);
    step("R3 open");
    seg(0,1,1,0,0,0);
    step("R3 sop open seg0");
    seg(0,1,0,1,0,0);
    step("R3 close");
    // missing start, R4
    seg(1,1,0,0,0,0);
    step("R4 no sop");
    seg(3,1,0,1,0,0);
    step("R4 close");
    clr = 1'b1;
    step("R9 clear");
    // error empty rule, R5
    seg(0,1,1,1,1,4'b1000);
    step("R5 legal err mty3");
    seg(0,1,1,1,1,4'b0011);
    step("R5 bad err mty");
    seg(0,1,1,0,1,4'b0111); seg(1,1,0,1,0,4'b0001);
    step("R5 err without eop");
    // multiple violations in one cycle, R8 priority
    clr = 1'b1;
    step("R9 clear2");
    seg(0,1,1,1,0,0); seg(1,1,1,1,1,4'b0100); seg(2,1,0,0,0,0); seg(3,1,1,1,0,0);
    step("R8 priority");
    seg(1,1,1,0,0,0); seg(2,1,1,1,1,4'b0010);
    step("R8 sop+mty same seg");
    step("R8 pulse drops");
    // clear coincident with violation, R9
    clr = 1'b1; seg(0,1,0,1,0,0);
    step("R9 clear with hit");
    step("R9 hold");
    clr = 1'b1;
    step("R9 clear only");
    // R11 field placement: bad empty only in segment 3
    seg(3,1,1,1,1,4'b0001); mty[3:0] = 4'b0111;
    step("R11 mty lane");
    // saturation, R10
    for (int i = 0; i < 20; i++) begin
      for (int k = 0; k < 4; k++) seg(k,1,1,1,k[0],0);
      step("R10 saturate");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule